// File: doc/BRIEF.md
# Accelerometer SPI Bring-up and Sample Streamer

This block is an SPI master that owns a three-axis accelerometer on a four-wire bus. After reset it reads the sensor's identity register and compares the value with an expected constant. If the value is wrong, it raises a sticky error and stops driving the bus. If the value matches, it writes four configuration registers in a fixed order, with one chip-select frame per write. The last of these writes puts the sensor into measurement mode.

After configuration the block watches the sensor's active-low data-ready line through a two-flop synchronizer. Each time that line is asserted and no frame is in progress, it issues one burst read of the six axis bytes under a single chip-select. It assembles the bytes into three signed 16-bit samples, low byte first, and pulses a one-cycle valid strobe once all three axes have been updated.

The serial clock runs in mode 3: it idles high, the master changes MOSI on falling edges, and data is sampled on rising edges. The serial clock is derived from the system clock by a half-period counter, so its rate is set by a parameter.

Top module: `accel_spi_seq`

## Requirements
- R1: While reset is held, CS_n and SCLK are high and both the valid strobe and the error flag are low. The first frame after reset is 16 bits long: address byte 0x80 (bit 7 = 1 marks a read, register 0x00) followed by 0x00.
- R2: If the identity byte returned in the second byte of that frame differs from EXPECT_ID (default 0xE5), the error flag goes high and stays high until reset. CS_n then remains high and no further frame is issued, even if the interrupt line is asserted.
- R3: When the identity matches, the next four frames are 16-bit writes (address bit 7 = 0) in this order: 0x31←0x20, 0x2E←0x80, 0x2C←0x0F, 0x2D←0x08. Each write has its own CS_n frame.
- R4: SCLK is high whenever CS_n is high. Each low phase and each high phase of SCLK lasts HALF_PERIOD_CYC system clocks. Within a frame, MOSI changes only on the clock in which SCLK falls, and bytes go out MSB first. The default of 25 gives 5 MHz from a 250 MHz clock.
- R5: CS_n changes only while SCLK is high. Between two frames, CS_n stays high for at least two SCLK half periods.
- R6: A data read is one 56-bit CS_n frame. It starts with address byte 0xF2 (bit 7 read, bit 6 multi-byte, register 0x32) and MOSI is 0 for the six data bytes that follow.
- R7: A data read starts only while the synchronized interrupt input is low, and never before the fourth configuration write has completed. If the interrupt is pending from reset onward, the read is the sixth frame.
- R8: The first two data bytes form the X sample, the next two Y and the last two Z, each as {second byte, first byte} read as signed. The valid strobe lasts exactly one cycle, and the sample outputs hold their values until the next strobe.
- R9: If the interrupt input is still low when a read frame and its inter-frame gap have ended, another read frame follows.
- R10: With a matching identity the error flag stays low. The valid strobe is never high while the error flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| spi_sclk | output | 1 | Serial clock, idles high (mode 3) |
| spi_mosi | output | 1 | Master-out serial data |
| spi_miso | input | 1 | Master-in serial data, sampled as SCLK rises |
| spi_cs_n | output | 1 | Active-low chip select, one assertion per frame |
| sensor_int_n | input | 1 | Active-low data-ready interrupt from the sensor, asynchronous |
| sample_x | output | 16 | Signed X-axis sample |
| sample_y | output | 16 | Signed Y-axis sample |
| sample_z | output | 16 | Signed Z-axis sample |
| sample_valid | output | 1 | One-cycle strobe when all three samples are updated |
| id_error | output | 1 | Sticky flag: the identity read returned the wrong value |

## Verification
The bench builds the block with HALF_PERIOD_CYC = 2 and CS_GAP_HALVES = 3. This shortens each 16-bit frame to about seventy cycles, so the identity failure, the full bring-up, several burst reads and back-to-back reads under a held interrupt all fit in a short run. With a half period of two clocks, the low-phase length, the placement of MOSI edges and the chip-select gap can each be measured exactly on every clock. The smaller gap is still longer than the two-stage interrupt synchronizer, so the case where the interrupt is released at the end of a read and must not start a second one is exercised at its tightest point.

// File: rtl/accel_seq_pkg.sv
package accel_seq_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_LOW,
    ENG_HIGH,
    ENG_GAP
  } eng_state_t;

  typedef enum logic [2:0] {
    CT_ID,
    CT_ID_WAIT,
    CT_CFG,
    CT_CFG_WAIT,
    CT_ARM,
    CT_RD_WAIT,
    CT_HALT
  } ctl_state_t;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } reg_write_t;

  localparam int AXES        = 3;
  localparam int DATA_BYTES  = 2 * AXES;
  localparam int BURST_LEN   = DATA_BYTES + 1;
  localparam int SINGLE_LEN  = 2;
  localparam int CFG_COUNT   = 4;

  localparam logic [7:0] FLAG_READ  = 8'h80;
  localparam logic [7:0] FLAG_MULTI = 8'h40;
  localparam logic [7:0] IDENT_REG  = 8'h00;
  localparam logic [7:0] AXIS_BASE  = 8'h32;

  // bring-up order matters: measurement mode must be entered last
  function automatic reg_write_t cfg_entry(input logic [1:0] idx);
    reg_write_t w;
    case (idx)
      2'd0:    w = '{addr: 8'h31, data: 8'h20};
      2'd1:    w = '{addr: 8'h2E, data: 8'h80};
      2'd2:    w = '{addr: 8'h2C, data: 8'h0F};
      default: w = '{addr: 8'h2D, data: 8'h08};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/reset_release_sync.sv
module reset_release_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/bit_sync2.sv
module bit_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      hold_q <= RESET_VAL;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/spi_mode3_engine.sv
module spi_mode3_engine
  import accel_seq_pkg::*;
#(
  parameter int HALF_PERIOD_CYC = 25,
  parameter int CS_GAP_HALVES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_addr,
  input  logic [7:0] tx_data,
  input  logic [2:0] frame_len,
  output logic       busy,
  output logic       done,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic [2:0] rx_index,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso,
  output logic       cs_n
);
  localparam int HCW = (HALF_PERIOD_CYC > 1) ? $clog2(HALF_PERIOD_CYC) : 1;
  localparam int GCW = (CS_GAP_HALVES > 1) ? $clog2(CS_GAP_HALVES) : 1;
  localparam logic [HCW-1:0] HLAST = HCW'(HALF_PERIOD_CYC - 1);
  localparam logic [GCW-1:0] GLAST = GCW'(CS_GAP_HALVES - 1);

  eng_state_t     st_q, st_d;
  logic [HCW-1:0] hcnt_q, hcnt_d;
  logic [GCW-1:0] gcnt_q, gcnt_d;
  logic [2:0]     bit_q, bit_d;
  logic [2:0]     byte_q, byte_d;
  logic [2:0]     len_q, len_d;
  logic [7:0]     tx_sh_q, tx_sh_d;
  logic [7:0]     sec_q, sec_d;
  logic [7:0]     rx_sh_q, rx_sh_d;
  logic [7:0]     rxb_q, rxb_d;
  logic [2:0]     rxi_q, rxi_d;
  logic           rxv_q, rxv_d;
  logic           done_q, done_d;
  logic           sclk_q, sclk_d;
  logic           cs_q, cs_d;
  logic           tick;

  assign tick = (hcnt_q == HLAST);

  always_comb begin
    st_d    = st_q;
    hcnt_d  = (st_q == ENG_IDLE || tick) ? '0 : hcnt_q + 1'b1;
    gcnt_d  = gcnt_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    len_d   = len_q;
    tx_sh_d = tx_sh_q;
    sec_d   = sec_q;
    rx_sh_d = rx_sh_q;
    rxb_d   = rxb_q;
    rxi_d   = rxi_q;
    rxv_d   = 1'b0;
    done_d  = 1'b0;
    sclk_d  = sclk_q;
    cs_d    = cs_q;
    case (st_q)
      ENG_IDLE: begin
        if (start) begin
          st_d    = ENG_SETUP;
          tx_sh_d = tx_addr;
          sec_d   = tx_data;
          len_d   = frame_len;
          bit_d   = '0;
          byte_d  = '0;
          cs_d    = 1'b0;
        end
      end
      ENG_SETUP: begin
        if (tick) begin
          st_d   = ENG_LOW;
          sclk_d = 1'b0;
        end
      end
      ENG_LOW: begin
        if (tick) begin
          st_d    = ENG_HIGH;
          sclk_d  = 1'b1;
          rx_sh_d = {rx_sh_q[6:0], miso};
        end
      end
      ENG_HIGH: begin
        if (tick) begin
          if (bit_q == 3'd7) begin
            rxv_d = 1'b1;
            rxb_d = rx_sh_q;
            rxi_d = byte_q;
            bit_d = '0;
            if (byte_q == (len_q - 3'd1)) begin
              st_d   = ENG_GAP;
              cs_d   = 1'b1;
              gcnt_d = '0;
            end else begin
              st_d    = ENG_LOW;
              sclk_d  = 1'b0;
              byte_d  = byte_q + 3'd1;
              tx_sh_d = (byte_q == 3'd0) ? sec_q : 8'h00;
            end
          end else begin
            st_d    = ENG_LOW;
            sclk_d  = 1'b0;
            bit_d   = bit_q + 3'd1;
            tx_sh_d = {tx_sh_q[6:0], 1'b0};
          end
        end
      end
      ENG_GAP: begin
        if (tick) begin
          if (gcnt_q == GLAST) begin
            st_d   = ENG_IDLE;
            done_d = 1'b1;
          end else begin
            gcnt_d = gcnt_q + 1'b1;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      hcnt_q  <= '0;
      gcnt_q  <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      len_q   <= '0;
      tx_sh_q <= '0;
      sec_q   <= '0;
      rx_sh_q <= '0;
      rxb_q   <= '0;
      rxi_q   <= '0;
      rxv_q   <= 1'b0;
      done_q  <= 1'b0;
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
    end else begin
      st_q    <= st_d;
      hcnt_q  <= hcnt_d;
      gcnt_q  <= gcnt_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
      len_q   <= len_d;
      tx_sh_q <= tx_sh_d;
      sec_q   <= sec_d;
      rx_sh_q <= rx_sh_d;
      rxb_q   <= rxb_d;
      rxi_q   <= rxi_d;
      rxv_q   <= rxv_d;
      done_q  <= done_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
    end
  end

  assign busy     = (st_q != ENG_IDLE);
  assign done     = done_q;
  assign rx_valid = rxv_q;
  assign rx_byte  = rxb_q;
  assign rx_index = rxi_q;
  assign sclk     = sclk_q;
  assign mosi     = tx_sh_q[7];
  assign cs_n     = cs_q;
endmodule

// File: rtl/accel_seq_ctrl.sv
module accel_seq_ctrl
  import accel_seq_pkg::*;
#(
  parameter logic [7:0] EXPECT_ID = 8'hE5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_active,
  input  logic       eng_busy,
  input  logic       eng_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic [2:0] rx_index,
  output logic       start,
  output logic [7:0] tx_addr,
  output logic [7:0] tx_data,
  output logic [2:0] frame_len,
  output logic       capture,
  output logic       id_error
);
  localparam int CIW = $clog2(CFG_COUNT);
  localparam logic [CIW-1:0] CLAST = CIW'(CFG_COUNT - 1);

  ctl_state_t     st_q, st_d;
  logic [CIW-1:0] cfg_q, cfg_d;
  logic [7:0]     id_q, id_d;
  logic           err_q, err_d;
  reg_write_t     cur_cfg;

  assign cur_cfg = cfg_entry(2'(cfg_q));

  always_comb begin
    st_d      = st_q;
    cfg_d     = cfg_q;
    id_d      = id_q;
    err_d     = err_q;
    start     = 1'b0;
    tx_addr   = 8'h00;
    tx_data   = 8'h00;
    frame_len = 3'(SINGLE_LEN);
    case (st_q)
      CT_ID: begin
        start   = 1'b1;
        tx_addr = FLAG_READ | IDENT_REG;
        st_d    = CT_ID_WAIT;
      end
      CT_ID_WAIT: begin
        if (rx_valid && rx_index == 3'd1) id_d = rx_byte;
        if (eng_done) begin
          if (id_q == EXPECT_ID) begin
            st_d  = CT_CFG;
            cfg_d = '0;
          end else begin
            st_d  = CT_HALT;
            err_d = 1'b1;
          end
        end
      end
      CT_CFG: begin
        start   = 1'b1;
        tx_addr = cur_cfg.addr;
        tx_data = cur_cfg.data;
        st_d    = CT_CFG_WAIT;
      end
      CT_CFG_WAIT: begin
        if (eng_done) begin
          if (cfg_q == CLAST) begin
            st_d = CT_ARM;
          end else begin
            cfg_d = cfg_q + 1'b1;
            st_d  = CT_CFG;
          end
        end
      end
      CT_ARM: begin
        tx_addr   = FLAG_READ | FLAG_MULTI | AXIS_BASE;
        frame_len = 3'(BURST_LEN);
        if (irq_active && !eng_busy) begin
          start = 1'b1;
          st_d  = CT_RD_WAIT;
        end
      end
      CT_RD_WAIT: begin
        if (eng_done) st_d = CT_ARM;
      end
      default: st_d = CT_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CT_ID;
      cfg_q <= '0;
      id_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cfg_q <= cfg_d;
      id_q  <= id_d;
      err_q <= err_d;
    end
  end

  assign capture  = (st_q == CT_RD_WAIT);
  assign id_error = err_q;
endmodule

// File: rtl/accel_sample_pack.sv
module accel_sample_pack
  import accel_seq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic                     rx_valid,
  input  logic [7:0]               rx_byte,
  input  logic [2:0]               rx_index,
  input  logic                     frame_done,
  output logic [AXES-1:0][15:0]    samples,
  output logic                     valid
);
  logic [DATA_BYTES-1:0][7:0] byte_q;
  logic [AXES-1:0][15:0]      smp_q, smp_d;
  logic                       vld_q, vld_d;
  logic                       publish;

  for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
    logic load;
    assign load = capture && rx_valid && (rx_index == 3'(b + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    byte_q[b] <= '0;
      else if (load) byte_q[b] <= rx_byte;
    end
  end

  assign publish = capture && frame_done;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    always_comb begin
      smp_d[a] = smp_q[a];
      if (publish) smp_d[a] = {byte_q[2*a+1], byte_q[2*a]};
    end
  end

  assign vld_d = publish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      smp_q <= smp_d;
      vld_q <= vld_d;
    end
  end

  assign samples = smp_q;
  assign valid   = vld_q;
endmodule

// File: rtl/accel_spi_seq.sv
module accel_spi_seq
  import accel_seq_pkg::*;
#(
  parameter int         HALF_PERIOD_CYC = 25,
  parameter int         CS_GAP_HALVES   = 2,
  parameter logic [7:0] EXPECT_ID       = 8'hE5
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               spi_cs_n,
  input  logic               sensor_int_n,
  output logic signed [15:0] sample_x,
  output logic signed [15:0] sample_y,
  output logic signed [15:0] sample_z,
  output logic               sample_valid,
  output logic               id_error
);
  logic                  core_rst_n;
  logic                  int_sync_n;
  logic                  eng_start, eng_busy, eng_done;
  logic [7:0]            eng_addr, eng_data;
  logic [2:0]            eng_len;
  logic                  rx_valid;
  logic [7:0]            rx_byte;
  logic [2:0]            rx_index;
  logic                  capture;
  logic [AXES-1:0][15:0] samples;

  reset_release_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  bit_sync2 #(.RESET_VAL(1'b1)) u_int_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     (sensor_int_n),
    .q     (int_sync_n)
  );

  accel_seq_ctrl #(.EXPECT_ID(EXPECT_ID)) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .irq_active (~int_sync_n),
    .eng_busy   (eng_busy),
    .eng_done   (eng_done),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_index   (rx_index),
    .start      (eng_start),
    .tx_addr    (eng_addr),
    .tx_data    (eng_data),
    .frame_len  (eng_len),
    .capture    (capture),
    .id_error   (id_error)
  );

  spi_mode3_engine #(
    .HALF_PERIOD_CYC (HALF_PERIOD_CYC),
    .CS_GAP_HALVES   (CS_GAP_HALVES)
  ) u_eng (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .start     (eng_start),
    .tx_addr   (eng_addr),
    .tx_data   (eng_data),
    .frame_len (eng_len),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_index  (rx_index),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .miso      (spi_miso),
    .cs_n      (spi_cs_n)
  );

  accel_sample_pack u_pack (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .capture    (capture),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .rx_index   (rx_index),
    .frame_done (eng_done),
    .samples    (samples),
    .valid      (sample_valid)
  );

  assign sample_x = samples[0];
  assign sample_y = samples[1];
  assign sample_z = samples[2];
endmodule

// File: rtl/accel_spi_seq_chk.sv
module accel_spi_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic spi_sclk,
  input logic spi_cs_n,
  input logic sample_valid,
  input logic id_error
);
  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R5
  cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> spi_sclk);

  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |=> spi_cs_n);

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |=> id_error);

  // R2
  halt_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |-> spi_cs_n);

  // R10
  no_valid_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |-> !sample_valid);
endmodule

bind accel_spi_seq accel_spi_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .spi_sclk     (spi_sclk),
  .spi_cs_n     (spi_cs_n),
  .sample_valid (sample_valid),
  .id_error     (id_error)
);

// File: tb/accel_spi_seq_test.sv
`timescale 1ns/1ps
module accel_spi_seq_test;
  localparam int HALF = 2;
  localparam int GAPH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk, spi_mosi, spi_cs_n;
  logic spi_miso = 1'b1;
  logic sensor_int_n;
  logic signed [15:0] sample_x, sample_y, sample_z;
  logic sample_valid, id_error;

  always #2 clk = ~clk;

  accel_spi_seq #(.HALF_PERIOD_CYC(HALF), .CS_GAP_HALVES(GAPH)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .sensor_int_n(sensor_int_n),
    .sample_x(sample_x), .sample_y(sample_y), .sample_z(sample_z),
    .sample_valid(sample_valid), .id_error(id_error));

  // sensor model state
  logic [7:0] sreg [0:63];
  int raise_cnt = 0;
  int serviced_cnt = 0;
  bit hold_low = 0;
  assign sensor_int_n = !((raise_cnt > serviced_cnt) || hold_low);

  // observed frames
  logic [55:0] frm_bits [$];
  int          frm_len  [$];
  int          valid_cnt = 0;

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errors = 0;

  // behavioural slave + per-clock bus reference
  logic        prev_sclk = 1'b1, prev_cs = 1'b1, prev_mosi = 1'b0;
  int          nb = 0, low_run = 0, gap_run = 1000;
  logic [55:0] bits = '0;
  logic [7:0]  addr_m = '0;
  always @(negedge clk) begin
    if (sample_valid) valid_cnt++;
    if (prev_cs && !spi_cs_n) begin
      mon_checks++;
      if (gap_run < 2*HALF) begin
        mon_errors++;
        $display("FAIL R5: cs high for %0d cycles, expected >= %0d", gap_run, 2*HALF);
      end
      nb = 0; bits = '0; low_run = 0; gap_run = 0;
    end
    if (spi_cs_n) gap_run++;
    if (!spi_cs_n && !prev_cs) begin
      if (!prev_sclk && spi_sclk) begin
        mon_checks++;
        if (low_run != HALF) begin
          mon_errors++;
          $display("FAIL R4: sclk low for %0d cycles, expected %0d", low_run, HALF);
        end
        low_run = 0;
        bits = {bits[54:0], spi_mosi};
        nb++;
        if (nb == 8) addr_m = bits[7:0];
      end
      if (prev_sclk && !spi_sclk && nb >= 8) begin
        automatic int j = (nb - 8) / 8;
        automatic logic [5:0] a = addr_m[6] ? (addr_m[5:0] + 6'(j)) : addr_m[5:0];
        spi_miso <= sreg[a][7 - (nb % 8)];
      end
      if (spi_mosi !== prev_mosi && !(prev_sclk && !spi_sclk)) begin
        mon_checks++; mon_errors++;
        $display("FAIL R4: mosi moved to %b without falling sclk, expected %b", spi_mosi, prev_mosi);
      end
    end
    if (!spi_sclk && !spi_cs_n) low_run++;
    if (!prev_cs && spi_cs_n) begin
      frm_bits.push_back(bits);
      frm_len.push_back(nb);
      if (nb >= 8 && addr_m == 8'hF2) serviced_cnt++;
    end
    prev_sclk = spi_sclk; prev_cs = spi_cs_n; prev_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk === 1'b1, "R1 sclk in reset", spi_sclk, 1);
    chk(sample_valid === 1'b0, "R1 valid in reset", sample_valid, 0);
    chk(id_error === 1'b0, "R1 error in reset", id_error, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_valid(input int limit, output bit got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sample_valid) begin got = 1; return; end
    end
  endtask

  task automatic check_samples(input logic [15:0] ex, input logic [15:0] ey, input logic [15:0] ez);
    chk(sample_x == ex, "R8 sample x", sample_x, ex);
    chk(sample_y == ey, "R8 sample y", sample_y, ey);
    chk(sample_z == ez, "R8 sample z", sample_z, ez);
  endtask

  task automatic load_axes(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    sreg[50] = x[7:0]; sreg[51] = x[15:8];
    sreg[52] = y[7:0]; sreg[53] = y[15:8];
    sreg[54] = z[7:0]; sreg[55] = z[15:8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  Result: errors=%0d of %0d checks", errors + mon_errors + 1, checks + mon_checks + 1);
    $finish;
  end

  initial begin
    int base;
    bit got;
    logic [15:0] cfg_exp [4];
    cfg_exp[0] = 16'h3120; cfg_exp[1] = 16'h2E80; cfg_exp[2] = 16'h2C0F; cfg_exp[3] = 16'h2D08;
    for (int i = 0; i < 64; i++) sreg[i] = 8'(i * 7 + 3);

    // identity mismatch
    sreg[0] = 8'h00;
    base = frm_len.size();
    do_reset();
    repeat (400) @(negedge clk);
    chk(id_error === 1'b1, "R2 error after bad id", id_error, 1);
    chk(frm_len.size() - base == 1, "R1 one frame issued", frm_len.size() - base, 1);
    chk(frm_len[base] == 16, "R1 id frame length", frm_len[base], 16);
    chk(frm_bits[base][15:0] == 16'h8000, "R1 id frame content", frm_bits[base][15:0], 16'h8000);
    raise_cnt++;
    repeat (400) @(negedge clk);
    chk(frm_len.size() - base == 1, "R2 halted with int asserted", frm_len.size() - base, 1);
    chk(id_error === 1'b1, "R2 error sticky", id_error, 1);
    chk(valid_cnt == 0, "R10 no valid while error", valid_cnt, 0);

    // good identity, interrupt already pending
    sreg[0] = 8'hE5;
    load_axes(16'h0123, 16'hFFF0, 16'h01FF);
    base = frm_len.size();
    do_reset();
    wait_valid(4000, got);
    chk(got, "R7 first read completes", got, 1);
    check_samples(16'h0123, 16'hFFF0, 16'h01FF);
    chk(id_error === 1'b0, "R10 error low on match", id_error, 0);
    chk(frm_len.size() - base == 6, "R7 read is sixth frame", frm_len.size() - base, 6);
    for (int i = 0; i < 4; i++) begin
      chk(frm_len[base+1+i] == 16, "R3 write frame length", frm_len[base+1+i], 16);
      chk(frm_bits[base+1+i][15:0] == cfg_exp[i], "R3 write order", frm_bits[base+1+i][15:0], cfg_exp[i]);
    end
    chk(frm_len[base+5] == 56, "R6 burst length", frm_len[base+5], 56);
    chk(frm_bits[base+5] == {8'hF2, 48'h0}, "R6 burst content", frm_bits[base+5], {8'hF2, 48'h0});
    @(negedge clk);
    chk(sample_valid === 1'b0, "R8 valid single cycle", sample_valid, 0);
    check_samples(16'h0123, 16'hFFF0, 16'h01FF);

    // no read while interrupt idle
    repeat (400) @(negedge clk);
    chk(frm_len.size() - base == 6, "R7 no read with int high", frm_len.size() - base, 6);

    // second read, negative values
    load_axes(16'hFE00, 16'h0000, 16'hFE01);
    raise_cnt++;
    wait_valid(2000, got);
    chk(got, "R8 second read completes", got, 1);
    check_samples(16'hFE00, 16'h0000, 16'hFE01);
    chk(frm_len.size() - base == 7, "R7 one read per assertion", frm_len.size() - base, 7);

    // held interrupt gives back-to-back reads
    load_axes(16'h0042, 16'h0100, 16'hFFFF);
    hold_low = 1;
    wait_valid(2000, got);
    wait_valid(2000, got);
    chk(got, "R9 repeated read under held int", got, 1);
    check_samples(16'h0042, 16'h0100, 16'hFFFF);
    hold_low = 0;
    repeat (400) @(negedge clk);
    chk(frm_len.size() - base >= 9, "R9 frames under held int", frm_len.size() - base, 9);
    chk(frm_bits[frm_bits.size()-1][55:48] == 8'hF2, "R9 last frame is read",
        frm_bits[frm_bits.size()-1][55:48], 8'hF2);
    chk(id_error === 1'b0, "R10 error stays low", id_error, 0);

    $display("  Result: errors=%0d of %0d checks", errors + mon_errors, checks + mon_checks);
    $finish;
  end
endmodule